// File: doc/BRIEF.md
# Receive Packet Ring Buffer Manager

This block keeps a circular receive buffer in a local byte memory that is organised in 256-byte pages. A byte address is the page number times 256 plus an offset. The ring covers the pages from a programmable first page up to, but not including, a programmable limit page. A write side takes one incoming frame at a time, byte by byte. It stores the payload behind a 4-byte header that begins at the current write page. After the last byte it fills in the header and advances the current write page past the frame.

A host finds the oldest unread frame one page past the boundary pointer. It aims an auto-incrementing read pointer at that frame with a seek command, and it streams the header and payload through a single data port. It then gives the space back with a release command that takes the next-frame page from the header. Two sticky flags report a stored frame and a dropped frame. Pointers that fall outside the ring are repaired without host action. The physical store holds `MEM_PAGES` pages, and page p sits in slot p mod `MEM_PAGES`, so the programmed ring must not span more pages than that.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the boundary reads 0x46, the current page 0x47, the first page 0x46, the limit page 0x60, the flag register 0, and `frame_ready` is low.
- R2: A stored frame of N payload bytes puts payload byte k at the address reached by advancing k+4 steps from the current page times 256. Offsets 0..3 of that page hold, in this order, the status byte taken at `in_end`, the next-frame page, and the low and high bytes of N+4.
- R3: A frame is dropped, `ovf_flag` is set and the current page stays unchanged when a byte would land in the boundary page or when the page after the frame equals the boundary.
- R4: A frame that is stored sets `pkt_flag` and moves the current page to its next-frame page, which is the page after the last page the frame occupies.
- R5: The flag register at address 7 holds the packet flag in bit 0 and the overflow flag in bit 1. Writing a one to a bit clears it.
- R6: The read page is the boundary plus one, or the first page when that sum reaches the limit page. `frame_ready` is low when the read page equals the current page.
- R7: `frame_ready` is low when the next-frame byte at offset 1 of the read page lies outside the first..limit-1 range, even though the ring is not empty.
- R8: Any write to address 5 sets the read pointer to the read page times 256. Reads of address 5 and address 6 return the low and high bytes of the read pointer.
- R9: A read of address 4 with `reg_rd` high returns the byte at the read pointer and advances the pointer. The advance that reaches the limit page times 256 goes to the first page times 256 instead.
- R10: Writing value n to address 6 sets the boundary to n-1, or to limit-1 when n is at most the first page.
- R11: When the boundary lies below the first page or at or above the limit page, the next clock sets the boundary to the first page and the current page to the first page plus one.
- R12: Addresses 0 to 3 read back and write the boundary, the current page, the first page and the limit page.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_start | input | 1 | Starts a new incoming frame |
| in_valid | input | 1 | `in_data` carries a payload byte |
| in_data | input | 8 | Payload byte |
| in_end | input | 1 | Ends the frame, at least one cycle after the last byte |
| in_stat | input | 8 | Status byte sampled with `in_end` |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host read strobe, which advances the pointer at address 4 |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for `reg_addr`, combinational |
| frame_ready | output | 1 | A valid frame waits at the read page |
| pkt_flag | output | 1 | Sticky flag for a stored frame |
| ovf_flag | output | 1 | Sticky flag for a dropped frame |

## Verification
The hardest situation to reach is a ring that is not empty but whose header at the read page carries an out-of-range next-frame page. That header would normally come from a frame that has not finished. The bench stores a directed 300-byte frame whose payload byte 253 lands at offset 1 of the second page and holds 0x10. It then moves the boundary so that the read page points into the middle of that frame. Overflow on a crowded ring, page and address wrap at the limit, and release wrap come from random frame lengths on a narrowed six-page ring, with a few directed pointer settings, and are checked against a bench model of the pointers and the memory.

// File: rtl/rxr_pkg.sv
// Shared definitions for the receive ring manager.
// Assumes 8-bit page numbers and 16-bit byte addresses (page * 256 + offset).
package rxr_pkg;

    // Host register addresses
    localparam logic [2:0] RA_BND   = 3'd0;
    localparam logic [2:0] RA_CURR  = 3'd1;
    localparam logic [2:0] RA_FIRST = 3'd2;
    localparam logic [2:0] RA_LIMIT = 3'd3;
    localparam logic [2:0] RA_DATA  = 3'd4;
    localparam logic [2:0] RA_SEEK  = 3'd5;
    localparam logic [2:0] RA_REL   = 3'd6;
    localparam logic [2:0] RA_FLAGS = 3'd7;

    // Write-side states
    typedef enum logic [1:0] {
        WS_IDLE,
        WS_RECV,
        WS_DROP,
        WS_HDR
    } wr_state_t;

    // Page after p inside the ring [s, e)
    function automatic logic [7:0] pg_next(input logic [7:0] p,
                                           input logic [7:0] s,
                                           input logic [7:0] e);
        logic [8:0] n;
        n = {1'b0, p} + 9'd1;
        return (n >= {1'b0, e}) ? s : n[7:0];
    endfunction

    // Byte address after a inside the ring [s*256, e*256)
    function automatic logic [15:0] addr_next(input logic [15:0] a,
                                              input logic [7:0]  s,
                                              input logic [7:0]  e);
        logic [16:0] n;
        n = {1'b0, a} + 17'd1;
        return (n >= {1'b0, e, 8'h00}) ? {s, 8'h00} : n[15:0];
    endfunction

endpackage

// File: rtl/rxr_store.sv
// Byte store for the ring: one synchronous write port and two combinational
// read ports (host data port and header peek).
// Assumes page p lives in slot p mod MEM_PAGES; MEM_PAGES is a power of two.
module rxr_store #(
    parameter int MEM_PAGES = 8
) (
    input  logic        clk,
    input  logic        we,
    input  logic [15:0] waddr,
    input  logic [7:0]  wdata,
    input  logic [15:0] raddr_a,
    output logic [7:0]  rdata_a,
    input  logic [15:0] raddr_b,
    output logic [7:0]  rdata_b
);
    localparam int IDX_W = $clog2(MEM_PAGES) + 8;
    localparam int DEPTH = MEM_PAGES * 256;

    logic [7:0] mem [DEPTH];

    // Store one byte per cycle
    always_ff @(posedge clk) begin
        if (we) mem[waddr[IDX_W-1:0]] <= wdata;
    end

    // Combinational read ports
    always_comb begin
        rdata_a = mem[raddr_a[IDX_W-1:0]];
        rdata_b = mem[raddr_b[IDX_W-1:0]];
    end
endmodule

// File: rtl/rxr_writer.sv
// Write side: places the payload of one frame after a 4-byte header at the
// current page, checks each byte against the boundary page, then writes the
// header in four cycles and hands the next-frame page to the pointer block.
// Assumes in_end comes after the last byte and the input stays idle for four
// cycles after in_end.
module rxr_writer
    import rxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_start,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_end,
    input  logic [7:0]  in_stat,
    input  logic [7:0]  bnd,
    input  logic [7:0]  curr,
    input  logic [7:0]  first_pg,
    input  logic [7:0]  limit_pg,
    output logic        mem_we,
    output logic [15:0] mem_waddr,
    output logic [7:0]  mem_wdata,
    output logic        commit,
    output logic [7:0]  commit_pg,
    output logic        ovf_evt
);
    wr_state_t   state;
    logic [15:0] wptr;
    logic [15:0] flen;
    logic [7:0]  nxt_pg;
    logic [7:0]  stat_q;
    logic [1:0]  hcnt;
    logic [7:0]  end_nxt;
    logic        hit_bnd;

    // Page after the last page the frame touched
    always_comb begin
        end_nxt = (wptr[7:0] == 8'h00) ? wptr[15:8]
                                       : pg_next(wptr[15:8], first_pg, limit_pg);
        hit_bnd = (wptr[15:8] == bnd);
    end

    // Memory write port and events
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = wptr;
        mem_wdata = in_data;
        ovf_evt   = 1'b0;
        case (state)
            WS_RECV: begin
                if (in_valid) begin
                    mem_we  = !hit_bnd;
                    ovf_evt = hit_bnd;
                end else if (in_end) begin
                    ovf_evt = (end_nxt == bnd);
                end
            end
            WS_HDR: begin
                mem_we    = 1'b1;
                mem_waddr = {curr, 6'd0, hcnt};
                case (hcnt)
                    2'd0:    mem_wdata = stat_q;
                    2'd1:    mem_wdata = nxt_pg;
                    2'd2:    mem_wdata = flen[7:0];
                    default: mem_wdata = flen[15:8];
                endcase
            end
            default: ;
        endcase
        commit    = (state == WS_HDR) && (hcnt == 2'd3);
        commit_pg = nxt_pg;
    end

    // Frame sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WS_IDLE;
            wptr   <= 16'h0;
            flen   <= 16'h0;
            nxt_pg <= 8'h0;
            stat_q <= 8'h0;
            hcnt   <= 2'd0;
        end else begin
            case (state)
                WS_IDLE: begin
                    if (in_start) begin
                        wptr  <= {curr, 8'h04};
                        flen  <= 16'd4;
                        state <= WS_RECV;
                    end
                end
                WS_RECV: begin
                    if (in_valid) begin
                        if (hit_bnd) begin
                            state <= WS_DROP;
                        end else begin
                            wptr <= addr_next(wptr, first_pg, limit_pg);
                            flen <= flen + 16'd1;
                        end
                    end else if (in_end) begin
                        stat_q <= in_stat;
                        nxt_pg <= end_nxt;
                        hcnt   <= 2'd0;
                        state  <= (end_nxt == bnd) ? WS_IDLE : WS_HDR;
                    end
                end
                WS_DROP: begin
                    if (in_end) state <= WS_IDLE;
                end
                WS_HDR: begin
                    hcnt <= hcnt + 2'd1;
                    if (hcnt == 2'd3) state <= WS_IDLE;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxr_ptrs.sv
// Pointer and register block: boundary, current page, ring limits, the host
// read pointer and the sticky flags, with ring repair on a bad boundary.
// Assumes the ring spans at least two pages.
module rxr_ptrs
    import rxr_pkg::*;
#(
    parameter logic [7:0] RST_FIRST = 8'h46,
    parameter logic [7:0] RST_LIMIT = 8'h60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        commit,
    input  logic [7:0]  commit_pg,
    input  logic        ovf_evt,
    input  logic [7:0]  port_byte,
    input  logic [7:0]  hdr_next,
    output logic [7:0]  bnd,
    output logic [7:0]  curr,
    output logic [7:0]  first_pg,
    output logic [7:0]  limit_pg,
    output logic [15:0] rptr,
    output logic [7:0]  rd_pg,
    output logic        frame_ready,
    output logic        pkt_flag,
    output logic        ovf_flag
);
    logic       bnd_bad;
    logic [7:0] rel_bnd;
    logic       wr_bnd, wr_curr, wr_seek, wr_rel, wr_flags;

    // Decode and derived pointers
    always_comb begin
        wr_bnd   = reg_wr && (reg_addr == RA_BND);
        wr_curr  = reg_wr && (reg_addr == RA_CURR);
        wr_seek  = reg_wr && (reg_addr == RA_SEEK);
        wr_rel   = reg_wr && (reg_addr == RA_REL);
        wr_flags = reg_wr && (reg_addr == RA_FLAGS);
        bnd_bad  = (bnd < first_pg) || (bnd >= limit_pg);
        rel_bnd  = (reg_wdata <= first_pg) ? (limit_pg - 8'd1) : (reg_wdata - 8'd1);
        rd_pg    = pg_next(bnd, first_pg, limit_pg);
        frame_ready = (rd_pg != curr) && (hdr_next >= first_pg) && (hdr_next < limit_pg);
    end

    // Boundary and current page, repair has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd  <= RST_FIRST;
            curr <= RST_FIRST + 8'd1;
        end else if (bnd_bad) begin
            bnd  <= first_pg;
            curr <= first_pg + 8'd1;
        end else begin
            if (wr_bnd)  bnd  <= reg_wdata;
            if (wr_rel)  bnd  <= rel_bnd;
            if (wr_curr) curr <= reg_wdata;
            if (commit)  curr <= commit_pg;
        end
    end

    // Ring limit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_pg <= RST_FIRST;
            limit_pg <= RST_LIMIT;
        end else if (reg_wr && reg_addr == RA_FIRST) begin
            first_pg <= reg_wdata;
        end else if (reg_wr && reg_addr == RA_LIMIT) begin
            limit_pg <= reg_wdata;
        end
    end

    // Host read pointer: seek or auto-increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= 16'h0;
        end else if (wr_seek) begin
            rptr <= {rd_pg, 8'h00};
        end else if (reg_rd && reg_addr == RA_DATA) begin
            rptr <= addr_next(rptr, first_pg, limit_pg);
        end
    end

    // Sticky flags, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (wr_flags && reg_wdata[0]) pkt_flag <= 1'b0;
            if (wr_flags && reg_wdata[1]) ovf_flag <= 1'b0;
            if (commit)  pkt_flag <= 1'b1;
            if (ovf_evt) ovf_flag <= 1'b1;
        end
    end

    // Host read mux
    always_comb begin
        case (reg_addr)
            RA_BND:   reg_rdata = bnd;
            RA_CURR:  reg_rdata = curr;
            RA_FIRST: reg_rdata = first_pg;
            RA_LIMIT: reg_rdata = limit_pg;
            RA_DATA:  reg_rdata = port_byte;
            RA_SEEK:  reg_rdata = rptr[7:0];
            RA_REL:   reg_rdata = rptr[15:8];
            default:  reg_rdata = {6'd0, ovf_flag, pkt_flag};
        endcase
    end
endmodule

// File: rtl/rx_ring_mgr.sv
// Top of the receive ring manager: joins the write side, the pointer block
// and the byte store. Assumes the programmed ring fits in MEM_PAGES pages.
module rx_ring_mgr #(
    parameter int         MEM_PAGES = 8,
    parameter logic [7:0] RST_FIRST = 8'h46,
    parameter logic [7:0] RST_LIMIT = 8'h60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_start,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_end,
    input  logic [7:0] in_stat,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       frame_ready,
    output logic       pkt_flag,
    output logic       ovf_flag
);
    logic [7:0]  bnd_q, curr_q, first_q, limit_q, rd_pg, port_byte, hdr_next, commit_pg;
    logic [15:0] rptr, mem_waddr;
    logic [7:0]  mem_wdata;
    logic        mem_we, commit, ovf_evt;

    rxr_writer u_wr (
        .clk(clk), .rst_n(rst_n),
        .in_start(in_start), .in_valid(in_valid), .in_data(in_data),
        .in_end(in_end), .in_stat(in_stat),
        .bnd(bnd_q), .curr(curr_q), .first_pg(first_q), .limit_pg(limit_q),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .commit(commit), .commit_pg(commit_pg), .ovf_evt(ovf_evt)
    );

    rxr_ptrs #(.RST_FIRST(RST_FIRST), .RST_LIMIT(RST_LIMIT)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .commit(commit), .commit_pg(commit_pg), .ovf_evt(ovf_evt),
        .port_byte(port_byte), .hdr_next(hdr_next),
        .bnd(bnd_q), .curr(curr_q), .first_pg(first_q), .limit_pg(limit_q),
        .rptr(rptr), .rd_pg(rd_pg), .frame_ready(frame_ready),
        .pkt_flag(pkt_flag), .ovf_flag(ovf_flag)
    );

    rxr_store #(.MEM_PAGES(MEM_PAGES)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(rptr), .rdata_a(port_byte),
        .raddr_b({rd_pg, 8'h01}), .rdata_b(hdr_next)
    );
endmodule

// File: rtl/rxr_ring_chk.sv
// Checker for the receive ring manager, bound to the top module.
module rxr_ring_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bnd,
    input logic [7:0] curr,
    input logic [7:0] first_pg,
    input logic [7:0] limit_pg,
    input logic       commit,
    input logic       mem_we,
    input logic       ovf_evt,
    input logic       pkt_flag,
    input logic       ovf_flag
);
    p_reinit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd < first_pg || bnd >= limit_pg) |=>
            (bnd == $past(first_pg) && curr == $past(first_pg) + 8'd1));

    p_pkt_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> pkt_flag);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);

    p_hdr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> mem_we);

    p_drop_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |-> !commit);
endmodule

bind rx_ring_mgr rxr_ring_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bnd(bnd_q), .curr(curr_q),
    .first_pg(first_q), .limit_pg(limit_q), .commit(commit),
    .mem_we(mem_we), .ovf_evt(ovf_evt), .pkt_flag(pkt_flag), .ovf_flag(ovf_flag)
);

// File: tb/sim_rx_ring_mgr.sv
module sim_rx_ring_mgr;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] FP = 8'h46;
    localparam logic [7:0] LP = 8'h4C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_start = 0, in_valid = 0, in_end = 0;
    logic [7:0] in_data = 0, in_stat = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic frame_ready, pkt_flag, ovf_flag;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0] mm [1536];
    logic [7:0] m_bnd, m_curr;
    int q_pg[$], q_nxt[$], q_len[$], q_st[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_ring_mgr u0 (
        .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_valid(in_valid),
        .in_data(in_data), .in_end(in_end), .in_stat(in_stat),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_ready(frame_ready), .pkt_flag(pkt_flag), .ovf_flag(ovf_flag)
    );

    function automatic logic [7:0] m_pg_next(logic [7:0] p);
        return (p + 8'd1 >= LP) ? FP : p + 8'd1;
    endfunction

    function automatic logic [15:0] m_addr_next(logic [15:0] a);
        return (a + 16'd1 >= {LP, 8'h00}) ? {FP, 8'h00} : a + 16'd1;
    endfunction

    function automatic int m_idx(logic [15:0] a);
        return int'(a) - int'({FP, 8'h00});
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic data_rd(output logic [7:0] v);
        @(negedge clk);
        reg_addr = 3'd4; reg_rd = 1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 0;
    endtask

    // Send one frame; predicts overflow and updates the model
    task automatic send(input int len, input int fidx, input logic [7:0] fval);
        int pages;
        bit ovf;
        logic [7:0] p, st, v;
        logic [15:0] a;
        pages = (len + 4 + 255) / 256;
        ovf = 0;
        p = m_curr;
        for (int k = 0; k < pages; k++) begin
            p = m_pg_next(p);
            if (p == m_bnd) ovf = 1;
        end
        st = 8'($urandom);
        a = {m_curr, 8'h04};
        @(negedge clk); in_start = 1;
        @(posedge clk); #1 in_start = 0;
        for (int i = 0; i < len; i++) begin
            v = (i == fidx) ? fval : 8'($urandom);
            if (!ovf) begin mm[m_idx(a)] = v; a = m_addr_next(a); end
            @(negedge clk); in_valid = 1; in_data = v;
            @(posedge clk); #1 in_valid = 0;
        end
        @(negedge clk); in_end = 1; in_stat = st;
        @(posedge clk); #1 in_end = 0;
        repeat (6) @(negedge clk);
        if (!ovf) begin
            q_pg.push_back(int'(m_curr)); q_nxt.push_back(int'(p));
            q_len.push_back(len + 4); q_st.push_back(int'(st));
            m_curr = p;
        end
        rd(3'd1, v);
        chk(v == m_curr, "R4 current page after frame", v, m_curr);
        rd(3'd7, v);
        chk(v == {6'd0, ovf, !ovf}, ovf ? "R3 overflow flag" : "R4 packet flag", v, {6'd0, ovf, !ovf});
        wr(3'd7, 8'h03);
        rd(3'd7, v);
        chk(v == 8'h00, "R5 flags cleared by write-one", v, 0);
    endtask

    // Read and release the oldest frame
    task automatic take();
        logic [7:0] lo, hi, h0, h1, h2, h3, v;
        logic [15:0] a;
        int err, n;
        @(negedge clk); #1;
        chk(frame_ready == 1'b1, "R6 frame_ready with stored frame", frame_ready, 1);
        wr(3'd5, 8'h00);
        rd(3'd5, lo); rd(3'd6, hi);
        chk({hi, lo} == {8'(q_pg[0]), 8'h00}, "R8 seek read pointer", {hi, lo}, {8'(q_pg[0]), 8'h00});
        data_rd(h0); data_rd(h1); data_rd(h2); data_rd(h3);
        chk(h0 == 8'(q_st[0]), "R2 header status", h0, q_st[0]);
        chk(h1 == 8'(q_nxt[0]), "R2 header next page", h1, q_nxt[0]);
        chk({h3, h2} == 16'(q_len[0]), "R2 header length", {h3, h2}, q_len[0]);
        a = {8'(q_pg[0]), 8'h04};
        err = 0;
        n = q_len[0] - 4;
        for (int i = 0; i < n; i++) begin
            data_rd(v);
            if (v !== mm[m_idx(a)]) err++;
            a = m_addr_next(a);
        end
        chk(err == 0, "R2 R9 payload through data port", err, 0);
        wr(3'd6, 8'(q_nxt[0]));
        m_bnd = (8'(q_nxt[0]) <= FP) ? LP - 8'd1 : 8'(q_nxt[0]) - 8'd1;
        rd(3'd0, v);
        chk(v == m_bnd, "R10 boundary after release", v, m_bnd);
        void'(q_pg.pop_front()); void'(q_nxt.pop_front());
        void'(q_len.pop_front()); void'(q_st.pop_front());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, lo, hi;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(3'd0, v); chk(v == 8'h46, "R1 reset boundary", v, 8'h46);
        rd(3'd1, v); chk(v == 8'h47, "R1 reset current page", v, 8'h47);
        rd(3'd2, v); chk(v == 8'h46, "R1 reset first page", v, 8'h46);
        rd(3'd3, v); chk(v == 8'h60, "R1 reset limit page", v, 8'h60);
        rd(3'd7, v); chk(v == 8'h00, "R1 reset flags", v, 0);
        chk(frame_ready == 1'b0, "R1 reset frame_ready", frame_ready, 0);
        // R12 narrow the ring
        wr(3'd3, LP);
        rd(3'd3, v); chk(v == LP, "R12 limit page write", v, LP);
        wr(3'd1, 8'h47);
        rd(3'd1, v); chk(v == 8'h47, "R12 current page write", v, 8'h47);
        // R11 repair of a bad boundary
        wr(3'd0, 8'h20);
        @(posedge clk); #1;
        rd(3'd0, v); chk(v == FP, "R11 boundary repaired", v, FP);
        rd(3'd1, v); chk(v == FP + 8'd1, "R11 current page repaired", v, FP + 8'd1);
        m_bnd = FP; m_curr = FP + 8'd1;
        // R7 invalid header at read page
        send(300, 253, 8'h10);
        wr(3'd0, 8'h47);
        @(negedge clk); #1;
        chk(frame_ready == 1'b0, "R7 out-of-range next page hides frame", frame_ready, 0);
        wr(3'd0, FP);
        take();
        // R6 read page wrap and R9 read pointer wrap
        wr(3'd0, LP - 8'd1);
        wr(3'd5, 8'h00);
        rd(3'd5, lo); rd(3'd6, hi);
        chk({hi, lo} == {FP, 8'h00}, "R6 read page wraps to first page", {hi, lo}, {FP, 8'h00});
        wr(3'd0, LP - 8'd2);
        wr(3'd5, 8'h00);
        for (int i = 0; i < 256; i++) data_rd(v);
        rd(3'd5, lo); rd(3'd6, hi);
        chk({hi, lo} == {FP, 8'h00}, "R9 read pointer wraps at limit", {hi, lo}, {FP, 8'h00});
        // R10 release wrap
        wr(3'd6, FP);
        rd(3'd0, v); chk(v == LP - 8'd1, "R10 release wraps to limit-1", v, LP - 8'd1);
        wr(3'd0, m_bnd);
        @(negedge clk); #1;
        chk(frame_ready == 1'b0, "R6 empty ring", frame_ready, 0);
        // Random mix
        for (int it = 0; it < 150; it++) begin
            if (($urandom % 3) != 0) begin
                send(int'($urandom % 520), -1, 8'h00);
            end else if (q_pg.size() != 0) begin
                take();
            end else begin
                @(negedge clk); #1;
                chk(frame_ready == 1'b0, "R6 empty ring", frame_ready, 0);
            end
        end
        while (q_pg.size() != 0) take();
        @(negedge clk); #1;
        chk(frame_ready == 1'b0, "R6 empty after drain", frame_ready, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule